// File: doc/BRIEF.md
# Modulo-Length Waveform Playback Addresser

This block produces read addresses for a 4096-entry waveform sample memory addressed with 12 bits. On every clock the address moves forward by a programmable integer step. When the new address would reach or pass a programmable sample length, it wraps modulo that length. The length does not have to be a power of two, so the output frequency is the clock rate times step divided by length.

With a 200 MHz clock, a length of 2000 and a step of 1 give 100,000 Hz. A length of 3999 and a step of 2 give about 100,025 Hz. Reading the full buffer one sample per clock gives about 48,828 Hz. A length of 4096 is the full buffer, where the wrap is the natural 12-bit rollover.

A one-cycle sync output marks every wrap. New length and step values are checked and then held in shadow registers. They take effect only at the next wrap, and the address restarts at 0 at that point. A rejected load leaves every setting unchanged and raises a one-cycle error output.

Top module: `wave_addr_gen`

## Requirements
- R1: After reset (rst_ni low), addr_o is 0, sync_o is 0 and err_o is 0. The active and shadow settings are length 4096 and step 1.
- R2: On each clock, with s = addr_o + step, addr_o becomes s when s < length. Otherwise it becomes s − length (no settings pending) or 0 (settings pending). Both cases use the active length and step.
- R3: sync_o is 1 in exactly those cycles whose addr_o value came from a wrap, that is, where the previous address plus step was at or above the active length.
- R4: A load is accepted when all of the following hold: the candidate length is in 2000..4096, the candidate step is in 1..2047, and step ≤ length. An accepted load is written to the shadow registers at the clock edge where the load is presented. It becomes active only at a later wrap edge; the wrap on the same edge as the load still uses the older shadow values.
- R5: At the wrap that makes shadow settings active, addr_o restarts at 0 and sync_o is 1.
- R6: A load that fails any R4 condition changes no setting. err_o is 1 for exactly the one cycle after that edge.
- R7: len_we_i and step_we_i are independent. A field whose write enable is low takes its pending shadow value for validation. A later accepted load before a wrap replaces an earlier one.
- R8: addr_o is always below the active length.
- R9: With length 4096, the address follows plain 12-bit rollover. With step 1 a wrap occurs every 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_we_i | input | 1 | Load strobe for the length |
| len_i | input | 13 | Requested sample length |
| step_we_i | input | 1 | Load strobe for the step |
| step_i | input | 11 | Requested address step |
| addr_o | output | 12 | Sample memory read address |
| sync_o | output | 1 | One-cycle pulse on each wrap |
| err_o | output | 1 | One-cycle pulse after a rejected load |

## Verification
A step of 1 with the default full-buffer length shows the plain rollover. Length 2000 with step 1 shows a non-power-of-two period. Length 3999 with step 2, loaded as two separate strobes, distinguishes correct shadow merging from a design that validates each field alone. The pair 2000/2000 makes every cycle a wrap, so a load lands on a wrap edge and shows whether the older shadow takes effect first. Invalid loads below the minimum length, above 4096, with a zero step, and with a step larger than the length show whether rejection truly keeps the prior settings.

// File: rtl/wag_pkg.sv
package wag_pkg;
  localparam int WAG_ADDR_W  = 12;
  localparam int WAG_STEP_W  = 11;
  localparam int WAG_MIN_LEN = 2000;

  typedef enum logic [1:0] {
    UPD_NONE   = 2'd0,
    UPD_STAGE  = 2'd1,
    UPD_REJECT = 2'd2
  } upd_e;
endpackage

// File: rtl/wag_validate.sv
module wag_validate
  import wag_pkg::*;
#(
  parameter int ADDR_W  = WAG_ADDR_W,
  parameter int STEP_W  = WAG_STEP_W,
  parameter int MIN_LEN = WAG_MIN_LEN
) (
  input  logic              len_we_i,
  input  logic [ADDR_W:0]   len_i,
  input  logic              step_we_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W:0]   shd_len_i,
  input  logic [STEP_W-1:0] shd_step_i,
  output upd_e              upd_o,
  output logic [ADDR_W:0]   cand_len_o,
  output logic [STEP_W-1:0] cand_step_o
);
  localparam int LEN_W   = ADDR_W + 1;
  localparam int MAX_LEN = 1 << ADDR_W;

  logic any_we, bad;

  always_comb begin
    any_we      = len_we_i | step_we_i;
    cand_len_o  = len_we_i  ? len_i  : shd_len_i;
    cand_step_o = step_we_i ? step_i : shd_step_i;
    bad = (cand_len_o < LEN_W'(MIN_LEN)) ||
          (cand_len_o > LEN_W'(MAX_LEN)) ||
          (cand_step_o == '0) ||
          (LEN_W'(cand_step_o) > cand_len_o);
    if (!any_we)  upd_o = UPD_NONE;
    else if (bad) upd_o = UPD_REJECT;
    else          upd_o = UPD_STAGE;
  end
endmodule

// File: rtl/wag_cfg_regs.sv
module wag_cfg_regs
  import wag_pkg::*;
#(
  parameter int ADDR_W = WAG_ADDR_W,
  parameter int STEP_W = WAG_STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  upd_e              upd_i,
  input  logic [ADDR_W:0]   cand_len_i,
  input  logic [STEP_W-1:0] cand_step_i,
  input  logic              apply_i,
  output logic [ADDR_W:0]   act_len_o,
  output logic [STEP_W-1:0] act_step_o,
  output logic [ADDR_W:0]   shd_len_o,
  output logic [STEP_W-1:0] shd_step_o,
  output logic              pend_o,
  output logic              err_o
);
  localparam int LEN_W   = ADDR_W + 1;
  localparam int MAX_LEN = 1 << ADDR_W;

  logic stage;
  assign stage = (upd_i == UPD_STAGE);

  // apply copies the old shadow; a load on the same edge re-arms pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_len_o  <= LEN_W'(MAX_LEN);
      act_step_o <= STEP_W'(1);
      shd_len_o  <= LEN_W'(MAX_LEN);
      shd_step_o <= STEP_W'(1);
      pend_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      if (apply_i) begin
        act_len_o  <= shd_len_o;
        act_step_o <= shd_step_o;
      end
      if (stage) begin
        shd_len_o  <= cand_len_i;
        shd_step_o <= cand_step_i;
      end
      pend_o <= stage | (pend_o & ~apply_i);
      err_o  <= (upd_i == UPD_REJECT);
    end
  end
endmodule

// File: rtl/wag_addr_acc.sv
module wag_addr_acc
  import wag_pkg::*;
#(
  parameter int ADDR_W = WAG_ADDR_W,
  parameter int STEP_W = WAG_STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W:0]   act_len_i,
  input  logic [STEP_W-1:0] act_step_i,
  input  logic              pend_i,
  output logic              apply_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sync_o
);
  localparam int SUM_W = ADDR_W + 2;

  logic [SUM_W-1:0]  sum;
  logic              wrap;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    sum     = SUM_W'(addr_o) + SUM_W'(act_step_i);
    wrap    = (sum >= SUM_W'(act_len_i));
    apply_o = wrap & pend_i;
    if (!wrap)      addr_d = ADDR_W'(sum);
    else if (pend_i) addr_d = '0;  // restart phase with new settings
    else            addr_d = ADDR_W'(sum - SUM_W'(act_len_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      sync_o <= 1'b0;
    end else begin
      addr_o <= addr_d;
      sync_o <= wrap;
    end
  end
endmodule

// File: rtl/wave_addr_gen.sv
module wave_addr_gen
  import wag_pkg::*;
#(
  parameter int ADDR_W  = WAG_ADDR_W,
  parameter int STEP_W  = WAG_STEP_W,
  parameter int MIN_LEN = WAG_MIN_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              len_we_i,
  input  logic [ADDR_W:0]   len_i,
  input  logic              step_we_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sync_o,
  output logic              err_o
);
  upd_e              upd;
  logic [ADDR_W:0]   cand_len, act_len, shd_len;
  logic [STEP_W-1:0] cand_step, act_step, shd_step;
  logic              pend, apply;

  wag_validate #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .MIN_LEN(MIN_LEN)) u_val (
    .len_we_i   (len_we_i),
    .len_i      (len_i),
    .step_we_i  (step_we_i),
    .step_i     (step_i),
    .shd_len_i  (shd_len),
    .shd_step_i (shd_step),
    .upd_o      (upd),
    .cand_len_o (cand_len),
    .cand_step_o(cand_step)
  );

  wag_cfg_regs #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (upd),
    .cand_len_i (cand_len),
    .cand_step_i(cand_step),
    .apply_i    (apply),
    .act_len_o  (act_len),
    .act_step_o (act_step),
    .shd_len_o  (shd_len),
    .shd_step_o (shd_step),
    .pend_o     (pend),
    .err_o      (err_o)
  );

  wag_addr_acc #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_len_i (act_len),
    .act_step_i(act_step),
    .pend_i    (pend),
    .apply_o   (apply),
    .addr_o    (addr_o),
    .sync_o    (sync_o)
  );
endmodule

// File: rtl/wag_chk.sv
module wag_chk #(
  parameter int ADDR_W = 12,
  parameter int STEP_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic              sync_o,
  input logic              err_o,
  input logic [ADDR_W:0]   act_len,
  input logic [STEP_W-1:0] act_step,
  input logic [ADDR_W:0]   shd_len,
  input logic [STEP_W-1:0] shd_step
);
  localparam int SUM_W = ADDR_W + 2;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R8
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ADDR_W + 1)'(addr_o) < act_len);

  // R2
  step_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !sync_o) |->
      SUM_W'(addr_o) == SUM_W'($past(addr_o)) + SUM_W'($past(act_step)));

  // R3
  wrap_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && sync_o) |->
      (SUM_W'($past(addr_o)) + SUM_W'($past(act_step))) >= SUM_W'($past(act_len)));

  // R4
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !sync_o) |-> ($stable(act_len) && $stable(act_step)));

  // R6
  reject_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && err_o) |-> ($stable(shd_len) && $stable(shd_step)));
endmodule

bind wave_addr_gen wag_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_o  (addr_o),
  .sync_o  (sync_o),
  .err_o   (err_o),
  .act_len (act_len),
  .act_step(act_step),
  .shd_len (shd_len),
  .shd_step(shd_step)
);

// File: tb/sim_wave_addr_gen.sv
`timescale 1ns/1ps
module sim_wave_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        len_we_i = 1'b0;
  logic [12:0] len_i = '0;
  logic        step_we_i = 1'b0;
  logic [10:0] step_i = '0;
  logic [11:0] addr_o;
  logic        sync_o, err_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk_i = ~clk_i;

  wave_addr_gen u0 (.*);

  // behavioural reference
  int m_addr = 0, m_len = 4096, m_step = 1, m_slen = 4096, m_sstep = 1;
  bit m_pend = 0, m_sync = 0, m_err = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_addr = 0; m_len = 4096; m_step = 1; m_slen = 4096; m_sstep = 1;
      m_pend = 0; m_sync = 0; m_err = 0;
    end else begin
      int s, nxt, cl, cs;
      bit w, bad, any;
      s = m_addr + m_step;
      w = (s >= m_len);
      nxt = !w ? s : (m_pend ? 0 : s - m_len);
      if (w && m_pend) begin m_len = m_slen; m_step = m_sstep; m_pend = 0; end
      any = len_we_i || step_we_i;
      cl = len_we_i ? int'(len_i) : m_slen;
      cs = step_we_i ? int'(step_i) : m_sstep;
      bad = any && (cl < 2000 || cl > 4096 || cs == 0 || cs > cl);
      if (any && !bad) begin m_slen = cl; m_sstep = cs; m_pend = 1; end
      m_err = bad; m_addr = nxt; m_sync = w;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      chk(int'(addr_o) == m_addr, "R2 addr", int'(addr_o), m_addr);
      chk(sync_o == m_sync, "R3 sync", int'(sync_o), int'(m_sync));
      chk(err_o == m_err, "R6 err", int'(err_o), int'(m_err));
      chk(int'(addr_o) < m_len, "R8 range", int'(addr_o), m_len);
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic load(input bit lw, input int l, input bit sw, input int s);
    len_we_i = lw; len_i = 13'(l); step_we_i = sw; step_i = 11'(s);
    @(negedge clk_i);
    len_we_i = 0; step_we_i = 0;
  endtask

  task automatic wait_sync();
    while (!sync_o) @(negedge clk_i);
  endtask

  task automatic count_sync(input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (sync_o) k++;
    end
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk(addr_o == 0, "R1 addr", int'(addr_o), 0);
    chk(sync_o == 0, "R1 sync", int'(sync_o), 0);
    chk(err_o == 0, "R1 err", int'(err_o), 0);
    rst_ni = 1'b1;
    // R9 full-buffer rollover, step 1
    count_sync(8192, k);
    chk(k == 2, "R9 wraps in 8192", k, 2);
    // R4 length 2000 step 1, held until wrap
    load(1, 2000, 1, 1);
    chk(addr_o != 0, "R4 not yet active", int'(addr_o), 1);
    wait_sync();
    chk(addr_o == 0, "R5 restart", int'(addr_o), 0);
    count_sync(4000, k);
    chk(k == 2, "R4 period 2000", k, 2);
    // R7 separate strobes: step 2 then length 3999
    load(0, 0, 1, 2);
    load(1, 3999, 0, 0);
    wait_sync();
    chk(addr_o == 0, "R5 restart 3999", int'(addr_o), 0);
    count_sync(3999, k);
    chk(k == 2, "R7 3999/2 wraps", k, 2);
    // R6 rejects
    load(1, 1999, 0, 0);
    chk(err_o == 1, "R6 len 1999", int'(err_o), 1);
    load(1, 4097, 0, 0);
    chk(err_o == 1, "R6 len 4097", int'(err_o), 1);
    load(0, 0, 1, 0);
    chk(err_o == 1, "R6 step 0", int'(err_o), 1);
    load(1, 2000, 1, 2047);
    chk(err_o == 1, "R6 step>len", int'(err_o), 1);
    @(negedge clk_i);
    chk(err_o == 0, "R6 one cycle", int'(err_o), 0);
    count_sync(8000, k);
    chk(k == 4, "R6 settings kept", k, 4);
    // step equal to length: every cycle wraps
    load(1, 2000, 1, 2000);
    wait_sync();
    count_sync(10, k);
    chk(k == 10, "R3 wrap every cycle", k, 10);
    // load on a wrap edge, then another before it applies
    load(1, 2500, 1, 7);
    load(1, 4096, 1, 2047);
    repeat (20) @(negedge clk_i);
    load(1, 4096, 1, 3);
    chk(err_o == 0, "R9 4096 accepted", int'(err_o), 0);
    repeat (9000) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule